// File: doc/BRIEF.md
# Adaptive Row-Close Interval Controller

This block decides when one tracked DRAM bank should have its open row closed. Each request to the bank reloads an idle countdown. If the countdown runs out before another request arrives, the block pulses a close flag for one cycle, and a scheduler outside the block acts on that flag.

The countdown length is not fixed. The block groups requests into windows of a programmable size and counts policy mistakes in each window. A mistake is either a conflict to a row that was still held open, which means the row was closed too late, or a return to the very row the timer just closed, which means it was closed too early. When a window ends, the mistake total is compared against a lower and an upper threshold. A low total makes the interval longer and a high total makes it shorter, each by 16 cycles per window. When adaptation is disabled, the interval follows the programmed starting value.

All configuration fields are coarse. The window length, starting interval and thresholds are programmed through their upper bits, and the bottom four bits are implied zero.

Top module: `page_close_adapt`

## Requirements
- R1: Reset must leave `close_o` at 0 and `interval_o` at 16, the row closed, and the window and mistake counters at zero.
- R2: While `cfg_en_i` is 0, `interval_o` must equal `cfg_init_i`×16, clamped to the range 16..4080, so a field of 0 gives 16. The new value must appear one clock edge after a field change.
- R3: Every request reloads the countdown with the current `interval_o` value I. If I consecutive edges then pass with no request, `close_o` must be 1 for exactly the one cycle after the I-th such edge. A request arriving before that edge must prevent the pulse.
- R4: A window must span `cfg_window_i`×16 requests, with a field of 0 treated as 1. Idle cycles must not advance the window.
- R5: A request with `same_row_i`=0 while the row is open counts as one mistake (late close), and it opens the new row.
- R6: A request with `same_row_i`=1 to a closed row whose last close came from the timer, with no request in between, counts as one mistake (premature close). A request with `same_row_i`=0 to a closed row must not count.
- R7: At a window end with `cfg_en_i`=1, if the mistake total (including the window's last request) is below `cfg_min_i`×16, the interval must grow by 16, saturating at 4080. This test takes priority over R8.
- R8: Otherwise, if the total is above `cfg_max_i`×16, the interval must shrink by 16, saturating at 16.
- R9: A total that lies within both thresholds must leave the interval unchanged. With `cfg_en_i`=0, window ends must not alter it. The mistake count must restart from zero in every window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | One request to the tracked bank this cycle |
| same_row_i | input | 1 | Request targets the last opened row |
| cfg_en_i | input | 1 | Adaptation enable |
| cfg_window_i | input | 8 | Window length in units of 16 requests |
| cfg_init_i | input | 8 | Starting interval in units of 16 cycles |
| cfg_min_i | input | 9 | Lower mistake threshold in units of 16 |
| cfg_max_i | input | 9 | Upper mistake threshold in units of 16 |
| close_o | output | 1 | One-cycle close-row pulse |
| interval_o | output | 12 | Current close interval in cycles |

## Verification
The close pulse is due exactly I edges after the edge that takes a request. The bench therefore counts falling edges from the end of that request and expects `close_o` high at count I and low at every other count. An interval update lands on the same edge that takes the window's final request, so the bench samples `interval_o` at the falling edge right after that request. A change to the programmed start value is checked one edge after it is driven. Since every input changes and every output is read at falling edges, no check depends on the order of events at a rising edge.

// File: rtl/pca_pkg.sv
package pca_pkg;
  localparam int PCA_CNT_W   = 12;
  localparam int PCA_FIELD_W = 8;
  localparam int PCA_THR_F_W = 9;
  localparam int PCA_SHIFT   = 4;

  typedef enum logic [1:0] {
    ADJ_HOLD,
    ADJ_LONGER,
    ADJ_SHORTER
  } adj_e;
endpackage

// File: rtl/pca_row_timer.sv
module pca_row_timer #(
  parameter int CNT_W = pca_pkg::PCA_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             same_row_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic             close_o,
  output logic             mistake_o
);
  logic             row_open_q, shut_q, close_q;
  logic [CNT_W-1:0] cnt_q;

  // late close: conflict on open row; premature: return to timer-closed row
  assign mistake_o = req_i & ((row_open_q & ~same_row_i) |
                              (~row_open_q & shut_q & same_row_i));
  assign close_o   = close_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_open_q <= 1'b0;
      shut_q     <= 1'b0;
      close_q    <= 1'b0;
      cnt_q      <= '0;
    end else begin
      close_q <= 1'b0;
      if (req_i) begin
        row_open_q <= 1'b1;
        shut_q     <= 1'b0;
        cnt_q      <= interval_i;
      end else if (row_open_q) begin
        if (cnt_q <= CNT_W'(1)) begin
          row_open_q <= 1'b0;
          shut_q     <= 1'b1;
          close_q    <= 1'b1;
          cnt_q      <= '0;
        end else begin
          cnt_q <= cnt_q - CNT_W'(1);
        end
      end
    end
  end

  // R3
  close_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_q |=> !close_q);
  // R3
  close_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    close_q |-> !$past(req_i));
endmodule

// File: rtl/pca_window_monitor.sv
module pca_window_monitor #(
  parameter int CNT_W   = pca_pkg::PCA_CNT_W,
  parameter int FIELD_W = pca_pkg::PCA_FIELD_W,
  parameter int SHIFT   = pca_pkg::PCA_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               mistake_i,
  input  logic [FIELD_W-1:0] win_field_i,
  output logic               win_end_o,
  output logic [CNT_W-1:0]   win_mist_o
);
  logic [CNT_W-1:0]   req_cnt_q, mist_q, mist_nxt, len_m1;
  logic [FIELD_W-1:0] field_eff;

  assign field_eff = (win_field_i == '0) ? FIELD_W'(1) : win_field_i;
  assign len_m1    = CNT_W'({field_eff, {SHIFT{1'b0}}}) - CNT_W'(1);
  assign mist_nxt  = (mistake_i && (mist_q != '1)) ? mist_q + CNT_W'(1) : mist_q;
  // >= keeps a mid-window shrink of the field from skipping the end
  assign win_end_o  = req_i && (req_cnt_q >= len_m1);
  assign win_mist_o = mist_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_cnt_q <= '0;
      mist_q    <= '0;
    end else if (req_i) begin
      if (win_end_o) begin
        req_cnt_q <= '0;
        mist_q    <= '0;
      end else begin
        req_cnt_q <= req_cnt_q + CNT_W'(1);
        mist_q    <= mist_nxt;
      end
    end
  end

  // R9
  mist_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_o |=> (mist_q == '0));
  // R4
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> $stable(req_cnt_q));
endmodule

// File: rtl/pca_interval_adapt.sv
module pca_interval_adapt #(
  parameter int CNT_W     = pca_pkg::PCA_CNT_W,
  parameter int FIELD_W   = pca_pkg::PCA_FIELD_W,
  parameter int THR_F_W   = pca_pkg::PCA_THR_F_W,
  parameter int SHIFT     = pca_pkg::PCA_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [FIELD_W-1:0] init_field_i,
  input  logic [THR_F_W-1:0] min_field_i,
  input  logic [THR_F_W-1:0] max_field_i,
  input  logic               win_end_i,
  input  logic [CNT_W-1:0]   win_mist_i,
  output logic [CNT_W-1:0]   interval_o
);
  import pca_pkg::*;

  localparam int THR_W = THR_F_W + SHIFT;
  localparam logic [CNT_W-1:0] STEP_V = CNT_W'(1 << SHIFT);
  localparam logic [CNT_W-1:0] HI_V   = CNT_W'((1 << CNT_W) - (1 << SHIFT));

  logic [CNT_W-1:0] interval_q, prog, prog_clamp;
  logic [THR_W-1:0] min_thr, max_thr, mist_ext;
  adj_e             adj;

  assign prog       = CNT_W'({init_field_i, {SHIFT{1'b0}}});
  assign prog_clamp = (prog < STEP_V) ? STEP_V : ((prog > HI_V) ? HI_V : prog);
  assign min_thr    = {min_field_i, {SHIFT{1'b0}}};
  assign max_thr    = {max_field_i, {SHIFT{1'b0}}};
  assign mist_ext   = THR_W'(win_mist_i);

  always_comb begin
    if (mist_ext < min_thr)      adj = ADJ_LONGER;
    else if (mist_ext > max_thr) adj = ADJ_SHORTER;
    else                         adj = ADJ_HOLD;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      interval_q <= STEP_V;
    end else if (!en_i) begin
      interval_q <= prog_clamp;
    end else if (win_end_i) begin
      unique case (adj)
        ADJ_LONGER:  interval_q <= (interval_q >= HI_V - STEP_V) ? HI_V : interval_q + STEP_V;
        ADJ_SHORTER: interval_q <= (interval_q <= STEP_V + STEP_V) ? STEP_V : interval_q - STEP_V;
        default:     interval_q <= interval_q;
      endcase
    end
  end

  assign interval_o = interval_q;

  // R2
  range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interval_q >= STEP_V) && (interval_q <= HI_V) && (interval_q[SHIFT-1:0] == '0));
  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && !$past(win_end_i)) |-> (interval_q == $past(interval_q)));
  // R7
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_i) && $past(win_end_i)) |->
      ((interval_q == $past(interval_q)) ||
       (interval_q == $past(interval_q) + STEP_V) ||
       (interval_q == $past(interval_q) - STEP_V)));
endmodule

// File: rtl/page_close_adapt.sv
module page_close_adapt #(
  parameter int CNT_W   = pca_pkg::PCA_CNT_W,
  parameter int FIELD_W = pca_pkg::PCA_FIELD_W,
  parameter int THR_F_W = pca_pkg::PCA_THR_F_W,
  parameter int SHIFT   = pca_pkg::PCA_SHIFT
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               same_row_i,
  input  logic               cfg_en_i,
  input  logic [FIELD_W-1:0] cfg_window_i,
  input  logic [FIELD_W-1:0] cfg_init_i,
  input  logic [THR_F_W-1:0] cfg_min_i,
  input  logic [THR_F_W-1:0] cfg_max_i,
  output logic               close_o,
  output logic [CNT_W-1:0]   interval_o
);
  logic             mistake, win_end;
  logic [CNT_W-1:0] win_mist, interval;

  pca_row_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .same_row_i (same_row_i),
    .interval_i (interval),
    .close_o    (close_o),
    .mistake_o  (mistake)
  );

  pca_window_monitor #(.CNT_W(CNT_W), .FIELD_W(FIELD_W), .SHIFT(SHIFT)) u_window (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .mistake_i   (mistake),
    .win_field_i (cfg_window_i),
    .win_end_o   (win_end),
    .win_mist_o  (win_mist)
  );

  pca_interval_adapt #(.CNT_W(CNT_W), .FIELD_W(FIELD_W), .THR_F_W(THR_F_W), .SHIFT(SHIFT)) u_adapt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (cfg_en_i),
    .init_field_i (cfg_init_i),
    .min_field_i  (cfg_min_i),
    .max_field_i  (cfg_max_i),
    .win_end_i    (win_end),
    .win_mist_i   (win_mist),
    .interval_o   (interval)
  );

  assign interval_o = interval;
endmodule

// File: tb/tb_page_close_adapt.sv
module tb_page_close_adapt;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        same_row_i = 1'b0;
  logic        cfg_en_i = 1'b0;
  logic [7:0]  cfg_window_i = '0;
  logic [7:0]  cfg_init_i = '0;
  logic [8:0]  cfg_min_i = '0;
  logic [8:0]  cfg_max_i = '0;
  logic        close_o;
  logic [11:0] interval_o;

  int n_cmp = 0;
  int n_bad = 0;
  int close_seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  page_close_adapt dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .same_row_i(same_row_i),
    .cfg_en_i(cfg_en_i), .cfg_window_i(cfg_window_i), .cfg_init_i(cfg_init_i),
    .cfg_min_i(cfg_min_i), .cfg_max_i(cfg_max_i),
    .close_o(close_o), .interval_o(interval_o)
  );

  always @(negedge clk_i) if (rst_ni && close_o) close_seen++;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic send(input bit same);
    @(negedge clk_i); req_i = 1'b1; same_row_i = same;
    @(negedge clk_i); req_i = 1'b0;
  endtask

  task automatic sends(input int n, input bit same);
    for (int i = 0; i < n; i++) send(same);
  endtask

  task automatic wait_close(input string tag);
    int k = 0;
    while (!close_o && k < 5000) begin @(negedge clk_i); k++; end
    chk(tag, int'(close_o), 1);
  endtask

  function automatic int clampi(input int v);
    return (v < 16) ? 16 : ((v > 4080) ? 4080 : v);
  endfunction

  initial begin
    int exp;
    int fl[5] = '{0, 1, 5, 128, 255};
    do_reset();
    chk("R1 close after reset", int'(close_o), 0);
    chk("R1 interval after reset", int'(interval_o), 16);

    foreach (fl[i]) begin
      cfg_init_i = 8'(fl[i]);
      @(negedge clk_i);
      chk("R2 programmed interval", int'(interval_o), clampi(fl[i] * 16));
    end

    // R3 close timing sweep
    for (int f = 1; f <= 3; f++) begin
      cfg_init_i = 8'(f);
      @(negedge clk_i);
      send(1'b1);
      for (int j = 1; j <= f * 16 + 2; j++) begin
        @(negedge clk_i);
        chk("R3 close cycle", int'(close_o), (j == f * 16) ? 1 : 0);
      end
    end

    // R3 reload prevents close
    cfg_init_i = 8'd1;
    @(negedge clk_i);
    send(1'b1);
    close_seen = 0;
    for (int r = 0; r < 5; r++) begin
      repeat (14) @(negedge clk_i);
      send(1'b1);
    end
    chk("R3 reload suppresses close", close_seen, 0);

    // adaptive lengthen sweep to saturation
    cfg_init_i = 8'd2; cfg_window_i = 8'd1; cfg_min_i = 9'd1; cfg_max_i = 9'd2; cfg_en_i = 1'b0;
    do_reset();
    cfg_en_i = 1'b1;
    exp = 32;
    chk("R2 start value", int'(interval_o), exp);
    while (exp < 4080) begin
      sends(16, 1'b1);
      exp += 16;
      chk("R7 lengthen step", int'(interval_o), exp);
    end
    sends(16, 1'b1);
    chk("R7 saturate 4080", int'(interval_o), 4080);

    // R9 between thresholds: 16 conflicts, 16 !< 16, 16 !> 32
    sends(16, 1'b0);
    chk("R9 between thresholds", int'(interval_o), 4080);

    // R8 shorten sweep: late-close conflicts above zero threshold
    cfg_min_i = 9'd0; cfg_max_i = 9'd0;
    while (exp > 16) begin
      sends(16, 1'b0);
      exp -= 16;
      chk("R8 shorten step R5", int'(interval_o), exp);
    end
    sends(16, 1'b0);
    chk("R8 saturate 16", int'(interval_o), 16);

    // R7 priority when min above max
    cfg_min_i = 9'd2; cfg_max_i = 9'd0;
    sends(16, 1'b0);
    chk("R7 lengthen wins", int'(interval_o), 32);

    // R4 window of 32 requests
    cfg_window_i = 8'd2; cfg_min_i = 9'd1; cfg_max_i = 9'd255;
    sends(16, 1'b1);
    chk("R4 no change mid-window", int'(interval_o), 32);
    sends(16, 1'b1);
    chk("R4 change at 32nd request", int'(interval_o), 48);

    // R9 adaptation off
    cfg_en_i = 1'b0; cfg_init_i = 8'd5; cfg_window_i = 8'd1;
    @(negedge clk_i);
    chk("R2 disable restores programmed", int'(interval_o), 80);
    sends(16, 1'b1);
    chk("R9 window end while disabled", int'(interval_o), 80);

    // R6 premature close, window field 0 acts as 16 (R4)
    cfg_init_i = 8'd4; cfg_window_i = 8'd0; cfg_min_i = 9'd0; cfg_max_i = 9'd0;
    do_reset();
    cfg_en_i = 1'b1;
    chk("R2 start 64", int'(interval_o), 64);
    sends(15, 1'b1);
    wait_close("R3 timer close");
    send(1'b1);
    chk("R6 premature counted R4", int'(interval_o), 48);
    sends(15, 1'b1);
    wait_close("R3 timer close");
    send(1'b0);
    chk("R6 new row not counted", int'(interval_o), 48);

    // R5 single late close in a window
    sends(15, 1'b1);
    send(1'b0);
    chk("R5 one conflict counted", int'(interval_o), 32);
    sends(16, 1'b1);
    chk("R9 count restarts", int'(interval_o), 32);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule